// File: doc/BRIEF.md
# Bang-Bang Phase Vote Tracker

This block is the digital half of a receive-side timing loop. Each cycle it receives two data samples and two edge samples from a double-rate sampler, together with the last data sample of the previous cycle. From these it decides whether the sampling clock is early or late. Each of the two bit slots gives its own early/late vote, and the two votes are merged into a single vote. That merged stream then passes through a cascade of rate-halving stages. A selector picks the stage whose output drives a 7-bit phase accumulator. The accumulator value weights a charge-pump current mismatch elsewhere, and that mismatch shifts the recovered clock phase.

The selector sets the loop bandwidth. Deeper stages update the accumulator less often. The nominal setting of 3 gives one possible update every eight cycles, which is 1/16 of the bit rate. When the accumulator reaches either end of its range it does not wrap. It turns its counting sense around, which avoids a full-scale jump in phase. Outside receive mode the accumulator and every decimation stage hold their state.

Top module: `phase_vote_tracker`

## Requirements
- R1: While `rstN` is low and after its release, `phaseCode` reads 64 (mid-scale) and the counting sense is forward.
- R2: Bit slot order within a cycle is dPrev, eEven, dEven, eOdd, dOdd. A slot whose two data bits differ votes up (late) when its edge differs from the earlier data bit, and votes down (early) when its edge differs from the later one. A slot whose data bits are equal casts no vote. With `bwSel` = 0 and forward sense, an up vote raises `phaseCode` by 1 and a down vote lowers it by 1.
- R3: The two slot votes merge so that one up and one down cancel. Two equal votes, or one vote alone, count as a single vote.
- R4: Each decimation stage pairs two consecutive votes from the stage below and combines them with the same cancel rule. With `bwSel` = k, the counter steps at most once per 2^k votes.
- R5: A `bwSel` value above the number of stages (4) acts as the deepest stage.
- R6: While `rxEn` is low, `phaseCode` holds and no vote is counted. The partial pairings in the decimation stages are kept and resume when `rxEn` returns.
- R7: A forward-sense increase requested at 127 gives 126 and reverses the sense. In reversed sense, up votes decrement and down votes increment.
- R8: A decrease requested at 0 gives 1 and reverses the sense again. `phaseCode` never jumps between 0 and 127.
- R9: `phaseCode` is registered and changes by at most 1 per clock. The change appears after the edge on which the selected vote is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per pair of bits |
| rstN | input | 1 | Active-low synchronous reset |
| rxEn | input | 1 | Receive mode enable |
| dPrev | input | 1 | Odd data sample from the previous cycle |
| eEven | input | 1 | Edge sample between dPrev and dEven |
| dEven | input | 1 | Even data sample |
| eOdd | input | 1 | Edge sample between dEven and dOdd |
| dOdd | input | 1 | Odd data sample |
| bwSel | input | 3 | Decimation stage feeding the counter (0 = undecimated) |
| phaseCode | output | 7 | Phase mismatch weight |

## Verification
A wrong pairing phase in a decimation stage shows at `phaseCode` within one vote period of the selected stage: a step comes one 2^k-vote group early or late. A wrong counting-sense bit shows on the very next vote as a step in the wrong direction. A fault in the detector or merge logic shows as a wrong step on the same clock when `bwSel` is 0. For these reasons the bench compares `phaseCode` after every single clock instead of only at the end of a run.

// File: rtl/phase_track_pkg.sv
package phase_track_pkg;

  typedef struct packed {
    logic vld;
    logic up;
    logic dn;
  } vote_t;

  // opposing votes cancel, a single or matching vote survives
  function automatic vote_t combineVotes(input vote_t a, input vote_t b, input logic vld);
    vote_t r;
    r.vld = vld;
    r.up  = vld & (a.up | b.up) & ~(a.dn | b.dn);
    r.dn  = vld & (a.dn | b.dn) & ~(a.up | b.up);
    return r;
  endfunction

endpackage

// File: rtl/decim_stage.sv
module decim_stage
  import phase_track_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  vote_t inV,
  output vote_t outV
);

  logic  half;
  vote_t held;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      half <= 1'b0;
      held <= '0;
    end else if (inV.vld) begin
      if (!half) begin
        held <= inV;
        half <= 1'b1;
      end else begin
        half <= 1'b0;
      end
    end
  end

  always_comb outV = combineVotes(held, inV, inV.vld & half);

  // R4: an emitted vote consumes the pair, so two outputs never come back to back
  a_r4_pairing: assert property (@(posedge clk) disable iff (!rstN)
    outV.vld |=> !outV.vld);

endmodule

// File: rtl/vote_ctrl.sv
module vote_ctrl
  import phase_track_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  localparam int SEL_W = $clog2(NUM_STAGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEn,
  input  logic             dPrev,
  input  logic             eEven,
  input  logic             dEven,
  input  logic             eOdd,
  input  logic             dOdd,
  input  logic [SEL_W-1:0] bwSel,
  output vote_t            strobe
);

  logic  xPrevE, xEvenE, xEvenO, xOddO;
  vote_t slotA, slotB;
  vote_t chain [NUM_STAGES+1];
  logic [SEL_W-1:0] selIdx;

  always_comb begin
    xPrevE = dPrev ^ eEven;
    xEvenE = eEven ^ dEven;
    xEvenO = dEven ^ eOdd;
    xOddO  = eOdd  ^ dOdd;
    slotA.vld = 1'b1;
    slotA.up  = xPrevE & ~xEvenE;
    slotA.dn  = xEvenE & ~xPrevE;
    slotB.vld = 1'b1;
    slotB.up  = xEvenO & ~xOddO;
    slotB.dn  = xOddO  & ~xEvenO;
    chain[0]  = combineVotes(slotA, slotB, rxEn);
  end

  for (genvar g = 1; g <= NUM_STAGES; g++) begin : g_stage
    decim_stage u_stage (
      .clk  (clk),
      .rstN (rstN),
      .inV  (chain[g-1]),
      .outV (chain[g])
    );
  end

  always_comb begin
    if (bwSel > SEL_W'(NUM_STAGES)) selIdx = SEL_W'(NUM_STAGES);
    else                            selIdx = bwSel;
    strobe = chain[selIdx];
  end

  // R3: merged and decimated strobes never request both directions
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.up && strobe.dn));

  // R6: no vote leaves the chain outside receive mode
  a_r6_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |-> !strobe.vld);

endmodule

// File: rtl/code_path.sv
module code_path
  import phase_track_pkg::*;
#(
  parameter int CODE_W = 7,
  localparam logic [CODE_W-1:0] CODE_MAX = '1,
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  vote_t             strobe,
  output logic [CODE_W-1:0] code
);

  logic rev;
  logic doStep, effUp;

  always_comb begin
    doStep = en & strobe.vld & (strobe.up | strobe.dn);
    effUp  = strobe.up ^ rev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      code <= CODE_MID;
      rev  <= 1'b0;
    end else if (doStep) begin
      if (effUp) begin
        if (code == CODE_MAX) begin
          code <= CODE_MAX - 1'b1;
          rev  <= ~rev;
        end else begin
          code <= code + 1'b1;
        end
      end else begin
        if (code == '0) begin
          code <= CODE_W'(1);
          rev  <= ~rev;
        end else begin
          code <= code - 1'b1;
        end
      end
    end
  end

  // R6: disabled receive mode freezes the code
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(code));

  // R9: at most one LSB of movement per clock
  a_r9_single_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (code == $past(code)) || (code == $past(code) + 1'b1) || (code == $past(code) - 1'b1));

  // R7: no wrap from full scale to zero
  a_r7_no_wrap_top: assert property (@(posedge clk) disable iff (!rstN)
    code == CODE_MAX |=> code != '0);

  // R8: no wrap from zero to full scale
  a_r8_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rstN)
    code == '0 |=> code != CODE_MAX);

endmodule

// File: rtl/phase_vote_tracker.sv
module phase_vote_tracker
  import phase_track_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int NUM_STAGES = 4,
  localparam int SEL_W = $clog2(NUM_STAGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              dPrev,
  input  logic              eEven,
  input  logic              dEven,
  input  logic              eOdd,
  input  logic              dOdd,
  input  logic [SEL_W-1:0]  bwSel,
  output logic [CODE_W-1:0] phaseCode
);

  vote_t strobe;

  vote_ctrl #(.NUM_STAGES(NUM_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rxEn   (rxEn),
    .dPrev  (dPrev),
    .eEven  (eEven),
    .dEven  (dEven),
    .eOdd   (eOdd),
    .dOdd   (dOdd),
    .bwSel  (bwSel),
    .strobe (strobe)
  );

  code_path #(.CODE_W(CODE_W)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .en     (rxEn),
    .strobe (strobe),
    .code   (phaseCode)
  );

endmodule

// File: tb/test_phase_vote_tracker.sv
module test_phase_vote_tracker;

  logic clk = 1'b0;
  logic rstN, rxEn, dPrev, eEven, dEven, eOdd, dOdd;
  logic [2:0] bwSel;
  logic [6:0] phaseCode;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  int expCode;
  bit expRev;
  bit ph [1:4];
  bit hu [1:4];
  bit hd [1:4];
  int unsigned lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  phase_vote_tracker i_phase_vote_tracker (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .dPrev(dPrev), .eEven(eEven),
    .dEven(dEven), .eOdd(eOdd), .dOdd(dOdd), .bwSel(bwSel), .phaseCode(phaseCode)
  );

  task automatic check(input string tag);
    vectors++;
    if (int'(phaseCode) != expCode) begin
      miscompares++;
      $display("FAIL %s: phaseCode=%0d expected=%0d", tag, phaseCode, expCode);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rxEn = 1'b0; bwSel = 3'd0;
    {dPrev, eEven, dEven, eOdd, dOdd} = 5'b0;
    repeat (3) @(negedge clk);
    expCode = 64; expRev = 0;
    for (int s = 1; s <= 4; s++) begin ph[s] = 0; hu[s] = 0; hd[s] = 0; end
    check("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release");
  endtask

  // pat = {dPrev, eEven, dEven, eOdd, dOdd}
  task automatic apply(input logic [4:0] pat, input bit en, input logic [2:0] sel, input string tag);
    bit ua, da, ub, db, u, d, v, fu, fd;
    int eff, req;
    @(negedge clk);
    {dPrev, eEven, dEven, eOdd, dOdd} = pat;
    rxEn = en; bwSel = sel;
    if (en) begin
      ua = (pat[4] != pat[2]) && (pat[3] != pat[4]);
      da = (pat[4] != pat[2]) && (pat[3] != pat[2]);
      ub = (pat[2] != pat[0]) && (pat[1] != pat[2]);
      db = (pat[2] != pat[0]) && (pat[1] != pat[0]);
      u = (ua || ub) && !(da || db);
      d = (da || db) && !(ua || ub);
      v = 1;
      eff = (sel > 4) ? 4 : int'(sel);
      fu = 0; fd = 0;
      if (eff == 0) begin fu = u; fd = d; end
      for (int s = 1; s <= 4; s++) begin
        if (v) begin
          if (!ph[s]) begin
            hu[s] = u; hd[s] = d; ph[s] = 1; v = 0;
          end else begin
            bit nu, nd;
            nu = (hu[s] || u) && !(hd[s] || d);
            nd = (hd[s] || d) && !(hu[s] || u);
            u = nu; d = nd; ph[s] = 0;
            if (s == eff) begin fu = u; fd = d; end
          end
        end
      end
      req = fu ? 1 : (fd ? -1 : 0);
      if (req != 0) begin
        if (expRev) req = -req;
        if (expCode + req > 127) begin expCode = 126; expRev = !expRev; end
        else if (expCode + req < 0) begin expCode = 1; expRev = !expRev; end
        else expCode = expCode + req;
      end
    end
    @(posedge clk);
    #2;
    check(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    doReset();

    // R2 / R3: every sample pattern with no decimation
    for (int p = 0; p < 32; p++) begin
      logic [4:0] pt;
      bit two;
      pt = 5'(p);
      two = (pt[4] != pt[2]) && (pt[2] != pt[0]);
      apply(pt, 1, 3'd0, two ? "R3 merged pattern" : "R2 single slot");
    end

    // R4 / R5: pseudo-random streams through every selector setting
    for (int s = 0; s < 8; s++) begin
      for (int n = 0; n < 48; n++) begin
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        apply(lfsr[4:0], 1, 3'(s), (s > 4) ? "R5 clamped select" : "R4 decimation");
      end
    end

    // R4: steady up votes at the nominal setting step once per eight
    doReset();
    for (int n = 0; n < 32; n++) apply(5'b01111, 1, 3'd3, "R4 nominal rate");

    // R6: pairing held across a disabled stretch
    doReset();
    apply(5'b01111, 1, 3'd1, "R6 first half");
    for (int n = 0; n < 6; n++) apply(5'b01111, 0, 3'd1, "R6 hold");
    apply(5'b01111, 1, 3'd1, "R6 resume");

    // R7 / R8: walk to both ends of the range
    doReset();
    for (int n = 0; n < 66; n++) apply(5'b01111, 1, 3'd0, "R7 top turn");
    apply(5'b00111, 1, 3'd0, "R7 reversed down");
    for (int n = 0; n < 130; n++) apply(5'b01111, 1, 3'd0, "R8 bottom turn");
    apply(5'b01111, 1, 3'd0, "R8 forward again");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule